// File: doc/BRIEF.md
# Comparator Edge Interrupt Controller

This block is the digital control logic that sits beside an analog comparator. The comparator output is taken in as a raw, asynchronous bit. The block passes it through a synchronizer, and it tells the analog side whether the comparator is switched on and whether the positive input should come from the external pin or from the internal reference. On the synchronized bit it looks for edges of the kind chosen by a two-bit mode field. Each matching edge sets a sticky interrupt flag. An interrupt-service acknowledge clears the flag, and so does writing a one to the flag bit.

The interrupt request is qualified by a local enable and by the processor's global interrupt enable. A separate capture-enable bit lets every output change, whatever the mode, send a single-cycle trigger to a timer's input-capture logic. Edge detection is held off in three cases: while the comparator is switched off, while the internal reference is selected but not yet ready, and for one sampled cycle after either of these conditions ends or after the input source is switched. This keeps a change of configuration from being seen as a comparator edge.

Software reaches the block through one 8-bit control and status register. A write updates the configuration fields in the same cycle, and a read returns the configuration, the flag and the synchronized comparator value.

Top module: `cmp_edge_irq`

## Requirements
- R1: The raw comparator bit is registered through two flops. A change on `cmp_raw_i` shows in read bit 7 on the second rising clock edge after the change, and not before.
- R2: With mode bits [6:5] = 00, both a rising and a falling change of the synchronized output set the flag (read bit 2) on the clock edge after the change reaches bit 7.
- R3: With mode 10, only a falling change (1 to 0) sets the flag.
- R4: With mode 11, only a rising change (0 to 1) sets the flag.
- R5: Mode 01 is reserved and never sets the flag.
- R6: While the off bit (bit 0) is 1, comparator changes neither set the flag nor pulse `cap_trig_o`.
- R7: A write with bit 2 = 1 clears the flag. A write with bit 2 = 0 leaves it unchanged. An event in the same cycle takes priority and keeps the flag set.
- R8: A one-cycle pulse on `irq_ack_i` clears the flag.
- R9: `irq_o` is 1 exactly when the flag, the interrupt enable (bit 3) and `gie_i` are all 1.
- R10: When capture enable (bit 4) is 1, every change of the synchronized output gives a `cap_trig_o` pulse lasting exactly one cycle, in the cycle the change appears in bit 7, regardless of mode. When bit 4 is 0, `cap_trig_o` stays 0.
- R11: In the first sampled cycle after the comparator becomes active, or after the reference-select bit (bit 1) changes, a change of the synchronized output produces neither an event nor a trigger.
- R12: While bit 1 selects the internal reference and `ref_ready_i` is 0, no events or triggers occur.
- R13: After reset, every register field is 0 and `irq_o` and `cap_trig_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw_i | input | 1 | Raw comparator output, asynchronous |
| ref_ready_i | input | 1 | Internal reference has settled |
| gie_i | input | 1 | Global interrupt enable |
| irq_ack_i | input | 1 | Interrupt-service acknowledge, clears the flag |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| cmp_on_o | output | 1 | Comparator power enable to the analog side |
| ref_int_o | output | 1 | Selects the internal reference as the positive input |
| irq_o | output | 1 | Qualified interrupt request |
| cap_trig_o | output | 1 | One-cycle input-capture trigger |

## Verification
On every cycle the assertions check that:
- no event or trigger occurs while the comparator is inactive or in a blanking cycle;
- the reserved mode stays silent;
- falling-mode and rising-mode events agree with the new output level;
- an event always leaves the flag set;
- an acknowledge or a write-one clears the flag;
- a trigger only appears with capture enabled.

Some properties need a known history of the input and the configuration, so only the bench's scenarios can show them. These are the two-cycle latency through the synchronizer, the suppression of a change that lines up exactly with an enable or a source switch, the gating by reference readiness, and the exact qualification of the request by `gie_i`.

// File: rtl/cmp_irq_pkg.sv
`timescale 1ns/1ps
package cmp_irq_pkg;

  localparam int REG_W = 8;

  // register bit positions
  localparam int B_OFF  = 0;
  localparam int B_REF  = 1;
  localparam int B_FLAG = 2;
  localparam int B_IEN  = 3;
  localparam int B_CAP  = 4;
  localparam int B_MLO  = 5;
  localparam int B_MHI  = 6;
  localparam int B_CMP  = 7;

  typedef enum logic [1:0] {
    MODE_ANY  = 2'b00,
    MODE_RSVD = 2'b01,
    MODE_FALL = 2'b10,
    MODE_RISE = 2'b11
  } edge_mode_e;

  typedef struct packed {
    edge_mode_e mode;
    logic       cap_en;
    logic       irq_en;
    logic       ref_int;
    logic       off;
  } ctrl_t;

  // does a transition prev->cur match the selected mode
  function automatic logic mode_hit(edge_mode_e m, logic prev, logic cur);
    case (m)
      MODE_ANY:  mode_hit = prev ^ cur;
      MODE_FALL: mode_hit = prev & ~cur;
      MODE_RISE: mode_hit = ~prev & cur;
      default:   mode_hit = 1'b0;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] pack_status(ctrl_t c, logic flag, logic cmp);
    logic [REG_W-1:0] r;
    r = '0;
    r[B_OFF]  = c.off;
    r[B_REF]  = c.ref_int;
    r[B_FLAG] = flag;
    r[B_IEN]  = c.irq_en;
    r[B_CAP]  = c.cap_en;
    r[B_MHI:B_MLO] = c.mode;
    r[B_CMP]  = cmp;
    return r;
  endfunction

endpackage

// File: rtl/cmp_sync.sv
`timescale 1ns/1ps
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= 1'b0;
      else        chain[i] <= chain[i-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/cmp_edge_det.sv
`timescale 1ns/1ps
module cmp_edge_det
  import cmp_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_i,
  input  logic       active_i,
  input  logic       ref_int_i,
  input  edge_mode_e mode_i,
  output logic       blank_o,
  output logic       change_o,
  output logic       evt_o
);
  logic prev_q;
  logic active_q;
  logic ref_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      active_q <= 1'b0;
      ref_q    <= 1'b0;
    end else begin
      prev_q   <= sync_i;
      active_q <= active_i;
      ref_q    <= ref_int_i;
    end
  end

  // first active cycle, or first cycle after a source switch
  assign blank_o  = active_i & (~active_q | (ref_int_i ^ ref_q));
  assign change_o = active_i & ~blank_o & (sync_i ^ prev_q);
  assign evt_o    = change_o & mode_hit(mode_i, prev_q, sync_i);
endmodule

// File: rtl/cmp_ctrl_regs.sv
`timescale 1ns/1ps
module cmp_ctrl_regs
  import cmp_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [REG_W-2:0] wr_data_i,
  input  logic             evt_i,
  input  logic             ack_i,
  output ctrl_t            ctrl_o,
  output logic             flag_o
);
  logic clr;

  assign clr = ack_i | (wr_en_i & wr_data_i[B_FLAG]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o <= '0;
    end else if (wr_en_i) begin
      ctrl_o.off     <= wr_data_i[B_OFF];
      ctrl_o.ref_int <= wr_data_i[B_REF];
      ctrl_o.irq_en  <= wr_data_i[B_IEN];
      ctrl_o.cap_en  <= wr_data_i[B_CAP];
      ctrl_o.mode    <= edge_mode_e'(wr_data_i[B_MHI:B_MLO]);
    end
  end

  // a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (evt_i) flag_o <= 1'b1;
    else if (clr)   flag_o <= 1'b0;
  end
endmodule

// File: rtl/cmp_edge_irq.sv
`timescale 1ns/1ps
module cmp_edge_irq
  import cmp_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_raw_i,
  input  logic             ref_ready_i,
  input  logic             gie_i,
  input  logic             irq_ack_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             cmp_on_o,
  output logic             ref_int_o,
  output logic             irq_o,
  output logic             cap_trig_o
);
  ctrl_t ctrl;
  logic  flag;
  logic  cmp_sync;
  logic  active_w;
  logic  blank_w;
  logic  change_w;
  logic  evt_w;
  logic  wr_unused;

  assign wr_unused = wr_data_i[B_CMP];

  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cmp_raw_i),
    .q_o   (cmp_sync)
  );

  assign active_w = ~ctrl.off & (~ctrl.ref_int | ref_ready_i);

  cmp_edge_det u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_i    (cmp_sync),
    .active_i  (active_w),
    .ref_int_i (ctrl.ref_int),
    .mode_i    (ctrl.mode),
    .blank_o   (blank_w),
    .change_o  (change_w),
    .evt_o     (evt_w)
  );

  cmp_ctrl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i[REG_W-2:0]),
    .evt_i     (evt_w),
    .ack_i     (irq_ack_i),
    .ctrl_o    (ctrl),
    .flag_o    (flag)
  );

  assign rd_data_o  = pack_status(ctrl, flag, cmp_sync);
  assign cmp_on_o   = ~ctrl.off;
  assign ref_int_o  = ctrl.ref_int;
  assign irq_o      = flag & ctrl.irq_en & gie_i;
  assign cap_trig_o = change_w & ctrl.cap_en;
endmodule

// File: rtl/cmp_edge_irq_chk.sv
`timescale 1ns/1ps
module cmp_edge_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] rd_data,
  input logic       irq,
  input logic       cap_trig,
  input logic       gie,
  input logic       ack,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       active,
  input logic       blank,
  input logic       change,
  input logic       evt
);
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[0] |-> !evt && !cap_trig); // R6
  AST_INACTIVE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !change); // R12
  AST_BLANK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> !change && !cap_trig); // R11
  AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[6:5] == 2'b01) |-> !evt); // R5
  AST_FALL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && rd_data[6:5] == 2'b10) |-> !rd_data[7]); // R3
  AST_RISE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && rd_data[6:5] == 2'b11) |-> rd_data[7]); // R4
  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> rd_data[2]); // R2
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !evt) |=> !rd_data[2]); // R8
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[2] && !evt) |=> !rd_data[2]); // R7
  AST_CAP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    cap_trig |-> rd_data[4]); // R10
  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> gie && rd_data[2] && rd_data[3]); // R9
endmodule

bind cmp_edge_irq cmp_edge_irq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_data  (rd_data_o),
  .irq      (irq_o),
  .cap_trig (cap_trig_o),
  .gie      (gie_i),
  .ack      (irq_ack_i),
  .wr_en    (wr_en_i),
  .wr_data  (wr_data_i),
  .active   (active_w),
  .blank    (blank_w),
  .change   (change_w),
  .evt      (evt_w)
);

// File: tb/cmp_edge_irq_tb.sv
`timescale 1ns/1ps
module cmp_edge_irq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_raw = 1'b0;
  logic       ref_ready = 1'b0;
  logic       gie = 1'b0;
  logic       ack = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       cmp_on, ref_int, irq, cap_trig;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // register fields
  localparam logic [7:0] OFF = 8'h01, REFI = 8'h02, FLG = 8'h04, IEN = 8'h08, CAP = 8'h10;
  localparam logic [7:0] M_ANY = 8'h00, M_RSV = 8'h20, M_FALL = 8'h40, M_RISE = 8'h60;

  always #2.5 clk = ~clk;

  cmp_edge_irq u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_raw_i(cmp_raw), .ref_ready_i(ref_ready),
    .gie_i(gie), .irq_ack_i(ack), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .cmp_on_o(cmp_on), .ref_int_o(ref_int),
    .irq_o(irq), .cap_trig_o(cap_trig)
  );

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    step(1);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  // configure and let the blanking cycle pass
  task automatic cfg(logic [7:0] d);
    wr(d);
    step(2);
  endtask

  // drive a new raw level and check trigger then flag
  task automatic drive(string req, logic v, logic exp_cap, logic exp_flag);
    cmp_raw = v;
    step(2);
    check(req, "cap_trig", {7'd0, cap_trig}, {7'd0, exp_cap});
    step(1);
    check(req, "flag", {7'd0, rd_data[2]}, {7'd0, exp_flag});
    check(req, "cap_trig after", {7'd0, cap_trig}, 8'd0);
  endtask

  task automatic t_reset();
    check("R13", "rd_data", rd_data, 8'h00);
    check("R13", "irq", {7'd0, irq}, 8'd0);
    check("R13", "cap", {7'd0, cap_trig}, 8'd0);
  endtask

  task automatic t_sync();
    cfg(OFF);
    cmp_raw = 1'b1;
    step(1);
    check("R1", "cmp after 1 edge", {7'd0, rd_data[7]}, 8'd0);
    step(1);
    check("R1", "cmp after 2 edges", {7'd0, rd_data[7]}, 8'd1);
    cmp_raw = 1'b0;
    step(3);
  endtask

  task automatic t_any_and_irq();
    cfg(M_ANY | IEN);
    drive("R2", 1'b1, 1'b0, 1'b1);
    gie = 1'b1; step(1);
    check("R9", "irq all set", {7'd0, irq}, 8'd1);
    gie = 1'b0; step(1);
    check("R9", "irq no gie", {7'd0, irq}, 8'd0);
    gie = 1'b1;
    wr(M_ANY);
    check("R9", "irq no local en", {7'd0, irq}, 8'd0);
    wr(M_ANY | IEN);
    check("R7", "write zero keeps flag", {7'd0, rd_data[2]}, 8'd1);
    wr(M_ANY | IEN | FLG);
    check("R7", "w1c clears flag", {7'd0, rd_data[2]}, 8'd0);
    check("R9", "irq after clear", {7'd0, irq}, 8'd0);
    gie = 1'b0;
    drive("R2", 1'b0, 1'b0, 1'b1);
    ack = 1'b1; step(1); ack = 1'b0;
    check("R8", "ack clears flag", {7'd0, rd_data[2]}, 8'd0);
  endtask

  task automatic t_fall();
    cfg(M_FALL);
    drive("R3", 1'b1, 1'b0, 1'b0);
    drive("R3", 1'b0, 1'b0, 1'b1);
    wr(M_FALL | FLG);
  endtask

  task automatic t_rise();
    cfg(M_RISE);
    drive("R4", 1'b1, 1'b0, 1'b1);
    wr(M_RISE | FLG);
    drive("R4", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_rsvd();
    cfg(M_RSV);
    drive("R5", 1'b1, 1'b0, 1'b0);
    drive("R5", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_cap();
    cfg(M_FALL | CAP);
    drive("R10", 1'b1, 1'b1, 1'b0);
    drive("R10", 1'b0, 1'b1, 1'b1);
    cfg(M_ANY | FLG);
    drive("R10", 1'b1, 1'b0, 1'b1);
    wr(M_ANY | FLG);
    drive("R10", 1'b0, 1'b0, 1'b1);
    wr(M_ANY | FLG);
  endtask

  task automatic t_off();
    cfg(M_ANY | CAP | OFF);
    check("R6", "cmp_on", {7'd0, cmp_on}, 8'd0);
    drive("R6", 1'b1, 1'b0, 1'b0);
    drive("R6", 1'b0, 1'b0, 1'b0);
  endtask

  // change reaches the synchronizer output in the same edge as the enable
  task automatic t_blank();
    cfg(M_ANY | CAP | OFF);
    cmp_raw = 1'b1;
    step(1);
    wr(M_ANY | CAP);
    check("R11", "cap on enable", {7'd0, cap_trig}, 8'd0);
    step(1);
    check("R11", "flag on enable", {7'd0, rd_data[2]}, 8'd0);
    ref_ready = 1'b1;
    step(1);
    cmp_raw = 1'b0;
    step(1);
    wr(M_ANY | CAP | REFI);
    check("R11", "ref_int", {7'd0, ref_int}, 8'd1);
    check("R11", "cap on source switch", {7'd0, cap_trig}, 8'd0);
    step(1);
    check("R11", "flag on source switch", {7'd0, rd_data[2]}, 8'd0);
  endtask

  task automatic t_ref_ready();
    ref_ready = 1'b0;
    cfg(M_ANY | CAP | REFI);
    drive("R12", 1'b1, 1'b0, 1'b0);
    ref_ready = 1'b1;
    step(2);
    drive("R12", 1'b0, 1'b1, 1'b1);
    wr(M_ANY | FLG);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_sync();
    t_any_and_irq();
    t_fall();
    t_rise();
    t_rsvd();
    t_cap();
    t_off();
    t_blank();
    t_ref_ready();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule